// File: doc/BRIEF.md
# Four-bit unsigned multiplier from two-bit partial products

This block multiplies two 4-bit unsigned operands into an 8-bit product using the vertical-and-crosswise method. Each operand is cut into a high and a low 2-bit half. Four small 2x2 multipliers form the low-by-low, the two cross and the high-by-high partial results, each 4 bits wide.

A chain of three 2-bit group adders then joins these four partial results at fixed offsets. Every small multiplier and every group adder is built from explicit half and full adder cells. A group passes its carry, which may be worth up to 2, to the next group. A parameter selects whether the product leaves through an output register, which costs one cycle, or straight from the adder network.

The block has no state machine and no handshake. With the register selected, a new operand pair may be applied every clock cycle.

Top module: `vm_mul4`

## Requirements
- R1: For every pair of 4-bit unsigned operands, `prod_o` equals the arithmetic product `a_i * b_i` (0 to 225).
- R2: Each 2x2 sub-multiplier returns the exact product of its two 2-bit halves, which is never above 9.
- R3: Product bits [1:0] equal bits [1:0] of `a_i[1:0] * b_i[1:0]`. When both operands are below 4, the whole product is that low-by-low result.
- R4: The group adders for product bits [3:2] and [5:4] carry a value of up to 2 into the next group, and the product stays exact when such carries occur (for example 15x15=225, 14x13=182, 11x11=121).
- R5: The top group (product bits [7:6]) never produces a carry, so every product fits in 8 bits.
- R6: With `REG_OUT`=1 (the default), the product for operands applied before a rising edge of `clk` appears after that edge. With `REG_OUT`=0, `prod_o` follows the operands with no clock.
- R7: While `rst_n` is low, the registered `prod_o` reads 0, whatever the operands are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low synchronous reset |
| a_i | input | 4 | Unsigned multiplicand |
| b_i | input | 4 | Unsigned multiplier |
| prod_o | output | 8 | Unsigned product |

## Verification
Two functions can fall in the same cycle: a group adder can take in a carry of 2 from the group below while its own three operand bits already fill the group. That gives a sum above 7, so the group sends a new carry onward at once. Both events are provoked by applying every one of the 256 operand pairs on back-to-back cycles. This includes the pairs of large operands in which both lower groups carry at once. Each registered product is judged against an arithmetic product that the bench computes on its own, one cycle after the pair was driven.

// File: rtl/vm_pkg.sv
package vm_pkg;
    localparam int OP_W   = 4;
    localparam int HALF_W = OP_W / 2;
    localparam int SUB_W  = 2 * HALF_W;
    localparam int PROD_W = 2 * OP_W;
    localparam int GROUPS = PROD_W / HALF_W - 1;

    typedef logic [HALF_W-1:0] half_t;
    typedef logic [SUB_W-1:0]  sub_t;
endpackage

// File: rtl/vm_ha.sv
module vm_ha (
    input  logic x_i,
    input  logic y_i,
    output logic s_o,
    output logic c_o
);
    assign s_o = x_i ^ y_i;
    assign c_o = x_i & y_i;
endmodule

// File: rtl/vm_fa.sv
module vm_fa (
    input  logic x_i,
    input  logic y_i,
    input  logic z_i,
    output logic s_o,
    output logic c_o
);
    assign s_o = x_i ^ y_i ^ z_i;
    assign c_o = (x_i & y_i) | (z_i & (x_i ^ y_i));
endmodule

// File: rtl/vm_mul2.sv
module vm_mul2
    import vm_pkg::*;
(
    input  half_t a_i,
    input  half_t b_i,
    output sub_t  q_o
);
    logic t_lo_hi, t_hi_lo, t_hi_hi, c_mid;

    assign q_o[0]  = a_i[0] & b_i[0];
    assign t_hi_lo = a_i[1] & b_i[0];
    assign t_lo_hi = a_i[0] & b_i[1];
    assign t_hi_hi = a_i[1] & b_i[1];

    vm_ha u_ha_mid (.x_i(t_hi_lo), .y_i(t_lo_hi), .s_o(q_o[1]), .c_o(c_mid));
    vm_ha u_ha_top (.x_i(t_hi_hi), .y_i(c_mid),   .s_o(q_o[2]), .c_o(q_o[3]));

    always_comb begin
        // R2
        sub_prod_chk: assert (q_o == sub_t'({2'b00, a_i} * {2'b00, b_i}));
        // R2
        sub_max_chk: assert (q_o <= sub_t'(9));
    end
endmodule

// File: rtl/vm_group.sv
module vm_group
    import vm_pkg::*;
(
    input  half_t x_i,
    input  half_t y_i,
    input  half_t z_i,
    input  half_t cin_i,
    output half_t sum_o,
    output half_t cout_o
);
    logic s_a, c_a, c_b, s_b, c_c, s_c, c_d, c_e;

    // column of weight 1 inside the group
    vm_fa u_fa0 (.x_i(x_i[0]), .y_i(y_i[0]), .z_i(z_i[0]), .s_o(s_a), .c_o(c_a));
    vm_ha u_ha0 (.x_i(s_a), .y_i(cin_i[0]), .s_o(sum_o[0]), .c_o(c_b));

    // column of weight 2 inside the group
    vm_fa u_fa1 (.x_i(x_i[1]), .y_i(y_i[1]), .z_i(z_i[1]), .s_o(s_b), .c_o(c_c));
    vm_fa u_fa2 (.x_i(s_b), .y_i(cin_i[1]), .z_i(c_a), .s_o(s_c), .c_o(c_d));
    vm_ha u_ha1 (.x_i(s_c), .y_i(c_b), .s_o(sum_o[1]), .c_o(c_e));

    // count of the three outgoing carries, as a binary value
    vm_fa u_fac (.x_i(c_c), .y_i(c_d), .z_i(c_e), .s_o(cout_o[0]), .c_o(cout_o[1]));
endmodule

// File: rtl/vm_mul4.sv
module vm_mul4
    import vm_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OP_W-1:0]   a_i,
    input  logic [OP_W-1:0]   b_i,
    output logic [PROD_W-1:0] prod_o
);
    sub_t  q_ll, q_hl, q_lh, q_hh;
    half_t gx [GROUPS];
    half_t gy [GROUPS];
    half_t gz [GROUPS];
    half_t gci [GROUPS];
    half_t gco [GROUPS];
    half_t gs [GROUPS];
    logic [PROD_W-1:0] prod_c;

    vm_mul2 u_ll (.a_i(a_i[HALF_W-1:0]),    .b_i(b_i[HALF_W-1:0]),    .q_o(q_ll));
    vm_mul2 u_hl (.a_i(a_i[OP_W-1:HALF_W]), .b_i(b_i[HALF_W-1:0]),    .q_o(q_hl));
    vm_mul2 u_lh (.a_i(a_i[HALF_W-1:0]),    .b_i(b_i[OP_W-1:HALF_W]), .q_o(q_lh));
    vm_mul2 u_hh (.a_i(a_i[OP_W-1:HALF_W]), .b_i(b_i[OP_W-1:HALF_W]), .q_o(q_hh));

    always_comb begin
        gx[0] = q_ll[SUB_W-1:HALF_W];
        gy[0] = q_hl[HALF_W-1:0];
        gz[0] = q_lh[HALF_W-1:0];
        gx[1] = q_hh[HALF_W-1:0];
        gy[1] = q_hl[SUB_W-1:HALF_W];
        gz[1] = q_lh[SUB_W-1:HALF_W];
        gx[2] = q_hh[SUB_W-1:HALF_W];
        gy[2] = '0;
        gz[2] = '0;
    end

    assign gci[0] = '0;

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        if (g > 0) begin : g_link
            assign gci[g] = gco[g-1];
        end
        vm_group u_grp (
            .x_i(gx[g]), .y_i(gy[g]), .z_i(gz[g]),
            .cin_i(gci[g]), .sum_o(gs[g]), .cout_o(gco[g])
        );
        assign prod_c[HALF_W*(g+2)-1 -: HALF_W] = gs[g];
    end

    assign prod_c[HALF_W-1:0] = q_ll[HALF_W-1:0];

    logic primed;
    always_ff @(posedge clk) begin
        if (!rst_n) primed <= 1'b0;
        else        primed <= 1'b1;
    end

    // R4
    low_carry_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gco[0] <= half_t'(2)) && (gco[1] <= half_t'(2)));

    // R5
    top_carry_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gco[GROUPS-1] == '0);

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n) prod_o <= '0;
            else        prod_o <= prod_c;
        end

        // R1
        reg_product_chk: assert property (@(posedge clk) disable iff (!rst_n)
            primed |-> prod_o == ({4'b0, $past(a_i)} * {4'b0, $past(b_i)}));

        // R7
        reset_clear_chk: assert property (@(posedge clk)
            $past(!rst_n) && primed == 1'b0 |-> prod_o == '0);
    end else begin : g_comb
        assign prod_o = prod_c;

        // R1
        comb_product_chk: assert property (@(posedge clk) disable iff (!rst_n)
            prod_o == ({4'b0, a_i} * {4'b0, b_i}));
    end
endmodule

// File: tb/sim_vm_mul4.sv
module sim_vm_mul4;
    typedef struct {
        logic [7:0] exp;
        logic [3:0] a;
        logic [3:0] b;
        string      tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] a_i = '0;
    logic [3:0] b_i = '0;
    logic [7:0] prod_o;

    int total = 0;
    int bad = 0;
    bit done = 0;
    item_t sb [$];

    always #4 clk = ~clk;

    vm_mul4 u0 (.clk(clk), .rst_n(rst_n), .a_i(a_i), .b_i(b_i), .prod_o(prod_o));

    task automatic drive(input logic [3:0] a, input logic [3:0] b, input string tag);
        item_t it;
        @(negedge clk);
        #1;
        a_i = a;
        b_i = b;
        it.a = a;
        it.b = b;
        it.tag = tag;
        it.exp = 8'({4'b0, a} * {4'b0, b});
        sb.push_back(it);
    endtask

    // monitor: one registered result per cycle, sampled at the falling edge
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                total++;
                if (prod_o !== it.exp) begin
                    bad++;
                    $display("FAIL %s: %0d x %0d got %0d expected %0d",
                             it.tag, it.a, it.b, prod_o, it.exp);
                end
            end
        end
    end

    initial begin
        // R7: product held at zero under reset with large operands applied
        a_i = 4'd15;
        b_i = 4'd15;
        repeat (3) @(negedge clk);
        total++;
        if (prod_o !== 8'd0) begin
            bad++;
            $display("FAIL R7: reset product got %0d expected 0", prod_o);
        end
        @(negedge clk);
        total++;
        if (prod_o !== 8'd0) begin
            bad++;
            $display("FAIL R7: reset product got %0d expected 0", prod_o);
        end
        rst_n = 1'b1;
        a_i = 4'd0;
        b_i = 4'd0;

        // R3: low-by-low only
        drive(4'd3, 4'd3, "R3");
        drive(4'd2, 4'd3, "R3");
        drive(4'd1, 4'd2, "R3");
        // R2: cross and high terms in isolation
        drive(4'd12, 4'd3, "R2");
        drive(4'd3, 4'd12, "R2");
        drive(4'd12, 4'd12, "R2");
        // R4: carries of up to 2 between groups
        drive(4'd15, 4'd15, "R4");
        drive(4'd14, 4'd13, "R4");
        drive(4'd11, 4'd11, "R4");
        // R5: largest product fits in 8 bits
        drive(4'd15, 4'd15, "R5");
        // R6: back-to-back pairs, each must show one cycle later
        drive(4'd7, 4'd9, "R6");
        drive(4'd0, 4'd15, "R6");
        drive(4'd9, 4'd7, "R6");
        // R1: exhaustive sweep
        for (int i = 0; i < 16; i++) begin
            for (int j = 0; j < 16; j++) begin
                drive(4'(i), 4'(j), "R1");
            end
        end
        repeat (3) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not end, got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule